// File: doc/BRIEF.md
# Reservation Monitor for Load-Linked / Store-Conditional

This block sits next to one processor's cache and turns a load-linked / store-conditional pair into an atomic read-modify-write. A load-linked operation records a reservation: a valid bit and the block address of the location. A later store-conditional to that block may write only if the reservation is still intact. In that case the monitor requests the shared bus and waits for a grant. When the grant arrives it issues the write on the bus and reports success to the processor. In every other case it reports failure and drives nothing onto the bus.

The monitor watches the snoop port for invalidating transactions from other agents. These are writes, invalidations, read-exclusives, and a competing store-conditional that won the bus. Any of them that hits the reserved block breaks the reservation. If a store-conditional is already waiting for the bus when this happens, the waiting store-conditional has lost and fails at once. The reservation is kept per block, so a hit on any byte of the block counts. Every store-conditional consumes the reservation, whether it succeeds or fails. A new load-linked overwrites any older reservation. The cache data itself is outside this block; only the reservation and the bus sequencing live here.

Top module: `resv_link_monitor`

## Requirements
- R1: While reset is asserted, and at the first edge after it, bus_req, bus_wr and st_valid are low, op_ready is high and no reservation exists. A store-conditional issued right after reset therefore fails.
- R2: A store-conditional (op_kind 3) is accepted when op_valid and op_ready are both high. If it hits the reserved block with the reservation intact, bus_req rises from the cycle after acceptance and stays high until the request resolves. op_ready is low for that whole time.
- R3: If bus_gnt is sampled high while waiting and no losing snoop is sampled, the next cycle shows the following for exactly one cycle: bus_wr=1, bus_wr_addr equal to the store-conditional address, st_valid=1 and st_ok=1. bus_req is low in that same cycle.
- R4: A store-conditional with no reservation, or one to a different block, reports st_valid=1 and st_ok=0 in the cycle after acceptance. It never raises bus_req or bus_wr.
- R5: An invalidating snoop (snp_valid=1, snp_inv=1) to the reserved block, sampled before or together with the store-conditional, makes that store-conditional fail without any bus request.
- R6: An invalidating snoop to the reserved block sampled while waiting for the bus makes the request fail in the next cycle: st_ok=0, bus_req drops and there is no bus_wr. This holds even when bus_gnt is high in the same cycle.
- R7: Blocks are 8 bytes: block address = addr[15:3]. An invalidating snoop to any byte of the reserved block breaks the reservation. A snoop to another block, or one with snp_inv=0, leaves it intact.
- R8: Every completed store-conditional, successful or failed, clears the reservation.
- R9: A load-linked (op_kind 2) replaces any earlier reservation. A load-linked accepted in the same cycle as a killing snoop to its block still establishes the reservation.
- R10: Ordinary loads (op_kind 0) and stores (op_kind 1) leave the reservation unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Processor operation present |
| op_kind | input | 2 | 0 load, 1 store, 2 load-linked, 3 store-conditional |
| op_addr | input | 16 | Byte address of the operation |
| op_ready | output | 1 | Monitor can accept an operation |
| st_valid | output | 1 | Store-conditional status present (one cycle) |
| st_ok | output | 1 | Status: 1 success, 0 failure |
| bus_req | output | 1 | Bus request for a winning store-conditional |
| bus_gnt | input | 1 | Bus grant |
| bus_wr | output | 1 | Store-conditional write placed on the bus (one cycle) |
| bus_wr_addr | output | 16 | Address of that bus write |
| snp_valid | input | 1 | Snooped bus transaction present |
| snp_inv | input | 1 | Snooped transaction invalidates the block |
| snp_addr | input | 16 | Address of the snooped transaction |

## Verification
Every result is due one clock after the edge that samples its cause. The status and bus write appear one cycle after the accepting edge, or one cycle after the edge that samples a grant or a losing snoop. The request line rises one cycle after the store-conditional is accepted. A broken reservation shows only as the outcome of a later store-conditional. The bench changes inputs 1 ns after a rising edge and compares all outputs on the falling edge against a behavioural model that advances on the rising edge. Each directed check is therefore taken at the first falling edge after the edge that should produce it.

// File: rtl/resv_pkg.sv
`timescale 1ns/1ps
package resv_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_LINK  = 2'd2,
    OP_COND  = 2'd3
  } op_kind_e;

  typedef enum logic {
    SC_IDLE = 1'b0,
    SC_WAIT = 1'b1
  } sc_state_e;
endpackage

// File: rtl/resv_link_reg.sv
`timescale 1ns/1ps
module resv_link_reg #(
  parameter int AW      = 16,
  parameter int BLK_OFF = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [AW-1:0] set_addr,
  input  logic          clr_en,
  input  logic          snp_valid,
  input  logic          snp_inv,
  input  logic [AW-1:0] snp_addr,
  input  logic [AW-1:0] op_addr,
  output logic          link_vld,
  output logic          op_match,
  output logic          snp_kill
);
  localparam logic [AW-1:0] BLK_MASK = {AW{1'b1}} << BLK_OFF;

  logic          vld_q, vld_d;
  logic [AW-1:0] blk_q, blk_d;

  always_comb begin
    op_match = vld_q && (((op_addr ^ blk_q) & BLK_MASK) == '0);
    snp_kill = vld_q && snp_valid && snp_inv &&
               (((snp_addr ^ blk_q) & BLK_MASK) == '0);
  end

  always_comb begin
    vld_d = vld_q;
    blk_d = blk_q;
    if (set_en) begin
      vld_d = 1'b1;
      blk_d = set_addr & BLK_MASK;
    end else if (clr_en || snp_kill) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      blk_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (set_en) blk_q <= blk_d;
    end
  end

  assign link_vld = vld_q;

  // R9
  set_then_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> (vld_q && (blk_q == $past(set_addr & BLK_MASK))));

  // R7
  kill_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_kill && !set_en) |=> !vld_q);
endmodule

// File: rtl/resv_sc_ctrl.sv
`timescale 1ns/1ps
module resv_sc_ctrl
  import resv_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [1:0]    op_kind,
  input  logic [AW-1:0] op_addr,
  input  logic          op_match,
  input  logic          snp_kill,
  input  logic          bus_gnt,
  output logic          op_ready,
  output logic          bus_req,
  output logic          link_set,
  output logic          link_clr,
  output logic          st_valid,
  output logic          st_ok,
  output logic          bus_wr,
  output logic [AW-1:0] bus_wr_addr
);
  sc_state_e     state_q, state_d;
  logic [AW-1:0] pend_q;
  logic          pend_en;
  logic          stv_q, stv_d, ok_q, ok_d, wr_q, wr_d;
  logic [AW-1:0] wa_q;
  logic          wa_en;
  logic          accept, is_ll, is_sc, sc_go;

  always_comb begin
    accept = op_valid && (state_q == SC_IDLE);
    is_ll  = accept && (op_kind_e'(op_kind) == OP_LINK);
    is_sc  = accept && (op_kind_e'(op_kind) == OP_COND);
    sc_go  = is_sc && op_match && !snp_kill;
  end

  always_comb begin
    state_d  = state_q;
    stv_d    = 1'b0;
    ok_d     = 1'b0;
    wr_d     = 1'b0;
    pend_en  = 1'b0;
    wa_en    = 1'b0;
    link_clr = 1'b0;
    case (state_q)
      SC_IDLE: begin
        if (sc_go) begin
          state_d = SC_WAIT;
          pend_en = 1'b1;
        end else if (is_sc) begin
          stv_d    = 1'b1;
          link_clr = 1'b1;
        end
      end
      SC_WAIT: begin
        if (snp_kill) begin
          state_d  = SC_IDLE;
          stv_d    = 1'b1;
          link_clr = 1'b1;
        end else if (bus_gnt) begin
          state_d  = SC_IDLE;
          stv_d    = 1'b1;
          ok_d     = 1'b1;
          wr_d     = 1'b1;
          wa_en    = 1'b1;
          link_clr = 1'b1;
        end
      end
      default: state_d = SC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SC_IDLE;
      pend_q  <= '0;
      stv_q   <= 1'b0;
      ok_q    <= 1'b0;
      wr_q    <= 1'b0;
      wa_q    <= '0;
    end else begin
      state_q <= state_d;
      stv_q   <= stv_d;
      ok_q    <= ok_d;
      wr_q    <= wr_d;
      if (pend_en) pend_q <= op_addr;
      if (wa_en)   wa_q   <= pend_q;
    end
  end

  assign link_set    = is_ll;
  assign op_ready    = (state_q == SC_IDLE);
  assign bus_req     = (state_q == SC_WAIT);
  assign st_valid    = stv_q;
  assign st_ok       = ok_q;
  assign bus_wr      = wr_q;
  assign bus_wr_addr = wa_q;

  // R3
  fail_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ok) |-> !bus_wr);

  // R3
  wr_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> $past(bus_req && bus_gnt));

  // R6
  lose_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && snp_kill) |=> (st_valid && !st_ok && !bus_wr && !bus_req));

  // R4
  no_link_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sc && !op_match) |=> (st_valid && !st_ok && !bus_req));

  // R2
  req_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_go |=> (bus_req && !op_ready));
endmodule

// File: rtl/resv_link_monitor.sv
`timescale 1ns/1ps
module resv_link_monitor #(
  parameter int AW      = 16,
  parameter int BLK_OFF = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [1:0]    op_kind,
  input  logic [AW-1:0] op_addr,
  output logic          op_ready,
  output logic          st_valid,
  output logic          st_ok,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          bus_wr,
  output logic [AW-1:0] bus_wr_addr,
  input  logic          snp_valid,
  input  logic          snp_inv,
  input  logic [AW-1:0] snp_addr
);
  logic link_vld, op_match, snp_kill, link_set, link_clr;

  resv_link_reg #(.AW(AW), .BLK_OFF(BLK_OFF)) u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_en    (link_set),
    .set_addr  (op_addr),
    .clr_en    (link_clr),
    .snp_valid (snp_valid),
    .snp_inv   (snp_inv),
    .snp_addr  (snp_addr),
    .op_addr   (op_addr),
    .link_vld  (link_vld),
    .op_match  (op_match),
    .snp_kill  (snp_kill)
  );

  resv_sc_ctrl #(.AW(AW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .op_kind     (op_kind),
    .op_addr     (op_addr),
    .op_match    (op_match),
    .snp_kill    (snp_kill),
    .bus_gnt     (bus_gnt),
    .op_ready    (op_ready),
    .bus_req     (bus_req),
    .link_set    (link_set),
    .link_clr    (link_clr),
    .st_valid    (st_valid),
    .st_ok       (st_ok),
    .bus_wr      (bus_wr),
    .bus_wr_addr (bus_wr_addr)
  );

  // R8
  wait_needs_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> link_vld);
endmodule

// File: tb/sim_resv_link_monitor.sv
`timescale 1ns/1ps
module sim_resv_link_monitor;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid, snp_valid, snp_inv, bus_gnt;
  logic [1:0]  op_kind;
  logic [15:0] op_addr, snp_addr;
  logic        op_ready, st_valid, st_ok, bus_req, bus_wr;
  logic [15:0] bus_wr_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // behavioural reference state
  bit          m_vld, m_wait, e_stv, e_ok, e_wr;
  logic [12:0] m_blk;
  logic [15:0] m_wa, e_wa;

  always #2.5 clk = ~clk;

  resv_link_monitor u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .op_addr(op_addr), .op_ready(op_ready), .st_valid(st_valid),
    .st_ok(st_ok), .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_wr(bus_wr),
    .bus_wr_addr(bus_wr_addr), .snp_valid(snp_valid), .snp_inv(snp_inv),
    .snp_addr(snp_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_vld = 0; m_wait = 0; m_blk = '0; m_wa = '0;
      e_stv = 0; e_ok = 0; e_wr = 0; e_wa = '0;
    end else begin
      bit kill;
      e_stv = 0; e_ok = 0; e_wr = 0;
      kill = snp_valid && snp_inv && m_vld && (snp_addr[15:3] == m_blk);
      if (m_wait) begin
        if (kill) begin
          m_vld = 0; m_wait = 0; e_stv = 1;
        end else if (bus_gnt) begin
          m_vld = 0; m_wait = 0; e_stv = 1; e_ok = 1; e_wr = 1; e_wa = m_wa;
        end
      end else begin
        if (kill) m_vld = 0;
        if (op_valid && op_kind == 2'd2) begin
          m_vld = 1; m_blk = op_addr[15:3];
        end else if (op_valid && op_kind == 2'd3) begin
          if (m_vld && op_addr[15:3] == m_blk) begin
            m_wait = 1; m_wa = op_addr;
          end else begin
            m_vld = 0; e_stv = 1;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 bus_req", bus_req, m_wait);
      chk("R2 op_ready", op_ready, !m_wait);
      chk("R3 st_valid", st_valid, e_stv);
      chk("R3 st_ok", st_ok, e_ok);
      chk("R3 bus_wr", bus_wr, e_wr);
      if (e_wr) chk("R3 bus_wr_addr", bus_wr_addr, e_wa);
    end
  end

  task automatic drive(input logic ov, input logic [1:0] k, input logic [15:0] a,
                       input logic sv, input logic si, input logic [15:0] sa,
                       input logic g);
    @(posedge clk);
    #1;
    op_valid = ov; op_kind = k; op_addr = a;
    snp_valid = sv; snp_inv = si; snp_addr = sa; bus_gnt = g;
  endtask

  task automatic idle_c();              drive(0, 2'd0, 16'h0, 0, 0, 16'h0, 0); endtask
  task automatic op_c(input logic [1:0] k, input logic [15:0] a);
    drive(1, k, a, 0, 0, 16'h0, 0);
  endtask
  task automatic snp_c(input logic inv, input logic [15:0] a);
    drive(0, 2'd0, 16'h0, 1, inv, a, 0);
  endtask
  task automatic gnt_c();               drive(0, 2'd0, 16'h0, 0, 0, 16'h0, 1); endtask
  // apply one stimulus cycle, then look at its result
  task automatic look();
    idle_c();
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    op_valid = 0; op_kind = 0; op_addr = 0;
    snp_valid = 0; snp_inv = 0; snp_addr = 0; bus_gnt = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset bus_req", bus_req, 0);
    chk("R1 reset bus_wr", bus_wr, 0);
    chk("R1 reset st_valid", st_valid, 0);
    chk("R1 reset op_ready", op_ready, 1);
    @(posedge clk); #1 rst_n = 1'b1;

    // R1/R4: no reservation after reset
    op_c(2'd3, 16'h0100); look();
    chk("R1 sc after reset st_valid", st_valid, 1);
    chk("R4 sc after reset st_ok", st_ok, 0);
    chk("R4 sc after reset bus_req", bus_req, 0);

    // R2/R3: success path with delayed grant
    op_c(2'd2, 16'h0100); op_c(2'd3, 16'h0100); look();
    chk("R2 req raised", bus_req, 1);
    chk("R2 not ready", op_ready, 0);
    idle_c(); idle_c();
    gnt_c(); look();
    chk("R3 bus_wr", bus_wr, 1);
    chk("R3 wr addr", bus_wr_addr, 16'h0100);
    chk("R3 ok", st_ok, 1);
    chk("R3 req dropped", bus_req, 0);

    // R8: reservation consumed by success
    op_c(2'd3, 16'h0100); look();
    chk("R8 second sc fails", st_ok, 0);
    chk("R8 second sc status", st_valid, 1);

    // R5/R7: snoop to another byte of the block before the SC
    op_c(2'd2, 16'h0200); snp_c(1, 16'h0204); op_c(2'd3, 16'h0200); look();
    chk("R5 fail status", st_valid, 1);
    chk("R5 fail ok", st_ok, 0);
    chk("R5 no req", bus_req, 0);

    // R7: other block and non-invalidating snoops keep the link
    op_c(2'd2, 16'h0300); snp_c(1, 16'h0308); snp_c(0, 16'h0300);
    op_c(2'd3, 16'h0301); look();
    chk("R7 link kept req", bus_req, 1);
    gnt_c(); look();
    chk("R7 success", st_ok, 1);
    chk("R7 addr", bus_wr_addr, 16'h0301);

    // R6: lose bus to snoop with grant in the same cycle
    op_c(2'd2, 16'h0400); op_c(2'd3, 16'h0400);
    drive(0, 2'd0, 16'h0, 1, 1, 16'h0402, 1); look();
    chk("R6 lost status", st_valid, 1);
    chk("R6 lost ok", st_ok, 0);
    chk("R6 no write", bus_wr, 0);
    chk("R6 req dropped", bus_req, 0);

    // R9: newer link replaces older one
    op_c(2'd2, 16'h0500); op_c(2'd2, 16'h0600); op_c(2'd3, 16'h0500); look();
    chk("R9 old block fails", st_ok, 0);
    chk("R9 old block status", st_valid, 1);
    op_c(2'd2, 16'h0600); op_c(2'd3, 16'h0600); gnt_c(); look();
    chk("R9 new block ok", st_ok, 1);
    // R9: link set together with a killing snoop still holds
    drive(1, 2'd2, 16'h0700, 1, 1, 16'h0700, 0);
    op_c(2'd3, 16'h0700); look();
    chk("R9 link beats snoop", bus_req, 1);
    gnt_c(); look();
    chk("R9 link beats snoop ok", st_ok, 1);

    // R10: ordinary load and store leave link alone
    op_c(2'd2, 16'h0800); op_c(2'd0, 16'h0800); op_c(2'd1, 16'h0808);
    op_c(2'd1, 16'h0800); op_c(2'd3, 16'h0800); look();
    chk("R10 link intact", bus_req, 1);
    gnt_c(); look();
    chk("R10 success", bus_wr, 1);

    // R4/R8: SC to other block fails and consumes the link
    op_c(2'd2, 16'h0900); op_c(2'd3, 16'h0948); look();
    chk("R4 other block fail", st_ok, 0);
    chk("R4 other block status", st_valid, 1);
    chk("R4 other block no req", bus_req, 0);
    op_c(2'd3, 16'h0900); look();
    chk("R8 failed sc cleared link", st_ok, 0);
    chk("R8 failed sc no req", bus_req, 0);

    repeat (3) idle_c();
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule